// File: doc/BRIEF.md
# Parallel Flash Write Cycle Sequencer

This block runs one asynchronous write cycle on a parallel NOR-style flash bus for a host. The host raises a request with an address and a 16-bit data word. The sequencer answers with a one-cycle acknowledge. It then drives chip enable, write enable, the address and the data bus in an order that meets every minimum setup, hold and pulse-width time of the write. All of these times are counted in cycles of the system clock.

Each minimum time is a parameter in picoseconds, next to the clock period. At elaboration each time becomes a cycle count: the time is divided by the period and rounded up, and the count is never less than one. The block also holds off the first write for a recovery time after reset. It keeps its busy output high until the gap after the write has elapsed, so the host can start a read as soon as busy falls.

With the default parameters (a 20 ns clock), the counts are as follows:
- reset recovery: 8 cycles
- enable setup: 1 cycle
- write pulse: 3 cycles
- hold: 1 cycle
- end-of-write gap: 1 cycle

Top module: `flash_wr_seq`

## Requirements
- R1: While reset is asserted and for REC cycles after it is released, the block holds busy_o high, ack_o low, fl_ce_n_o and fl_we_n_o high and fl_dq_oe_o low. REC is the ceiling of 150 ns over the clock period, which is 8 cycles by default.
- R2: A request seen at a clock edge while busy_o is low is accepted. In the next cycle ack_o is high for exactly one cycle and busy_o goes high. The address and data captured at that edge appear on fl_addr_o and fl_dq_o.
- R3: A request made while busy_o is high is ignored. It produces no acknowledge, and it does not change the address or data of the write in progress.
- R4: fl_ce_n_o goes low in the acceptance cycle and stays low for CES cycles before fl_we_n_o falls. CES is the enable setup time rounded up, with a minimum of 1.
- R5: fl_we_n_o stays low for exactly PW consecutive cycles. PW is the larger of the pulse-width time and the data/address setup time, each rounded up (3 cycles by default). fl_we_n_o is never low while fl_ce_n_o is high.
- R6: fl_dq_oe_o is high from the cycle in which fl_we_n_o falls through the hold window, and at no other time. fl_addr_o stays stable for as long as fl_ce_n_o is low.
- R7: After fl_we_n_o rises, fl_ce_n_o stays low and the address and data stay driven for HOLD cycles, with a minimum of 1.
- R8: After the hold window, busy_o stays high for GAP cycles with enable and write enable high and the data bus released. GAP is the larger of the pulse-high time and the write-to-read turnaround, rounded up. Whenever busy_o is low, fl_dq_oe_o is low and fl_ce_n_o is high.
- R9: Every phase length equals the ceiling of its time divided by the clock period and is at least one cycle. The full write therefore takes CES+PW+HOLD+GAP busy cycles (6 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts the recovery window |
| req_i | input | 1 | Write request |
| addr_i | input | ADDR_W | Write address |
| data_i | input | DATA_W | Write data word |
| ack_o | output | 1 | One-cycle acknowledge of an accepted request |
| busy_o | output | 1 | High during recovery and from acceptance until the end gap has elapsed |
| fl_addr_o | output | ADDR_W | Flash address bus |
| fl_dq_o | output | DATA_W | Flash data bus value |
| fl_dq_oe_o | output | 1 | Data bus output enable |
| fl_ce_n_o | output | 1 | Flash chip enable, active low |
| fl_we_n_o | output | 1 | Flash write enable, active low |

## Verification
The bench holds the request high straight out of reset, so a design that ignored the recovery window would pulse write enable early. Requests are also held high across whole writes and pulsed in the middle of them. A sequencer that re-accepts while busy, or re-latches its inputs, would show a second acknowledge or corrupted address and data during the write pulse. Every cycle is compared against a model that counts the age of each write, so a phase one cycle too short or too long is caught: a shortened pulse or hold, a missing end gap, or a data bus left driven after busy falls. A reset in the middle of a write checks that the bus returns to idle and that recovery starts again.

// File: rtl/flash_wr_pkg.sv
package flash_wr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD,
        PH_GAP
    } phase_e;

    // ceiling of t_ps / clk_ps, never below one cycle
    function automatic int unsigned ps_to_cyc(input int unsigned t_ps,
                                              input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a,
                                          input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/flash_wr_rec_gate.sv
module flash_wr_rec_gate #(
    parameter int unsigned REC_C = 8,
    localparam int unsigned RW   = $clog2(REC_C + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic done_o
);

    typedef struct packed {
        logic [RW-1:0] cnt;
        logic          done;
    } rec_s;

    rec_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!r_q.done) begin
            if (r_q.cnt == '0) r_d.done = 1'b1;
            else               r_d.cnt  = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cnt  <= RW'(REC_C - 1);
            r_q.done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o = r_q.done;

    // R1
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> r_q.done);

endmodule

// File: rtl/flash_wr_phase_timer.sv
module flash_wr_phase_timer #(
    parameter int unsigned TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          zero_o
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)              cnt_d = load_val_i;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R9
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq
    import flash_wr_pkg::*;
#(
    parameter int unsigned ADDR_W       = 24,
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned CLK_PS       = 20000,
    parameter int unsigned T_RST_REC_PS = 150000,
    parameter int unsigned T_CE_SU_PS   = 0,
    parameter int unsigned T_WP_PS      = 50000,
    parameter int unsigned T_DSU_PS     = 50000,
    parameter int unsigned T_HOLD_PS    = 0,
    parameter int unsigned T_WPH_PS     = 20000,
    parameter int unsigned T_TURN_PS    = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ack_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic [DATA_W-1:0] fl_dq_o,
    output logic              fl_dq_oe_o,
    output logic              fl_ce_n_o,
    output logic              fl_we_n_o
);

    localparam int unsigned REC_C  = ps_to_cyc(T_RST_REC_PS, CLK_PS);
    localparam int unsigned CES_C  = ps_to_cyc(T_CE_SU_PS, CLK_PS);
    localparam int unsigned PW_C   = max_u(ps_to_cyc(T_WP_PS, CLK_PS),
                                           ps_to_cyc(T_DSU_PS, CLK_PS));
    localparam int unsigned HOLD_C = ps_to_cyc(T_HOLD_PS, CLK_PS);
    localparam int unsigned GAP_C  = max_u(ps_to_cyc(T_WPH_PS, CLK_PS),
                                           ps_to_cyc(T_TURN_PS, CLK_PS));
    localparam int unsigned MAX_C  = max_u(max_u(CES_C, PW_C), max_u(HOLD_C, GAP_C));
    localparam int unsigned TW     = $clog2(MAX_C + 1);

    typedef struct packed {
        phase_e            ph;
        logic              ce_n;
        logic              we_n;
        logic              dq_oe;
        logic              ack;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } seq_s;

    seq_s          s_d, s_q;
    logic          rec_done;
    logic          tmr_zero;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;

    flash_wr_rec_gate #(.REC_C(REC_C)) i_rec (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_o (rec_done)
    );

    flash_wr_phase_timer #(.TW(TW)) i_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    always_comb begin
        s_d      = s_q;
        s_d.ack  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (s_q.ph)
            PH_IDLE: begin
                if (rec_done && req_i) begin
                    s_d.ph   = PH_SETUP;
                    s_d.ack  = 1'b1;
                    s_d.addr = addr_i;
                    s_d.data = data_i;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(CES_C - 1);
                end
            end
            PH_SETUP: begin
                if (tmr_zero) begin
                    s_d.ph   = PH_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PW_C - 1);
                end
            end
            PH_PULSE: begin
                if (tmr_zero) begin
                    s_d.ph   = PH_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HOLD_C - 1);
                end
            end
            PH_HOLD: begin
                if (tmr_zero) begin
                    s_d.ph   = PH_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(GAP_C - 1);
                end
            end
            PH_GAP: begin
                if (tmr_zero) s_d.ph = PH_IDLE;
            end
            default: s_d.ph = PH_IDLE;
        endcase

        // pin levels registered from the next phase
        s_d.ce_n  = !(s_d.ph == PH_SETUP || s_d.ph == PH_PULSE || s_d.ph == PH_HOLD);
        s_d.we_n  = (s_d.ph != PH_PULSE);
        s_d.dq_oe = (s_d.ph == PH_PULSE || s_d.ph == PH_HOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph    <= PH_IDLE;
            s_q.ce_n  <= 1'b1;
            s_q.we_n  <= 1'b1;
            s_q.dq_oe <= 1'b0;
            s_q.ack   <= 1'b0;
            s_q.addr  <= '0;
            s_q.data  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ack_o      = s_q.ack;
    assign busy_o     = !rec_done || (s_q.ph != PH_IDLE);
    assign fl_addr_o  = s_q.addr;
    assign fl_dq_o    = s_q.data;
    assign fl_dq_oe_o = s_q.dq_oe;
    assign fl_ce_n_o  = s_q.ce_n;
    assign fl_we_n_o  = s_q.we_n;

    // run-length counter of write enable low, checker only
    logic [TW-1:0] we_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          we_run_q <= '0;
        else if (!fl_we_n_o) we_run_q <= we_run_q + 1'b1;
        else                 we_run_q <= '0;
    end

    // R1
    no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n_o |-> rec_done);

    // R2
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R3
    ack_only_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ($past(req_i) && busy_o));

    // R5
    we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n_o |-> !fl_ce_n_o);

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we_n_o && we_run_q != '0) |-> (we_run_q == TW'(PW_C)));

    // R6
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_ce_n_o && !$past(fl_ce_n_o) && !ack_o) |-> $stable(fl_addr_o));

    // R7
    hold_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n_o) |-> (fl_dq_oe_o && !fl_ce_n_o));

    // R8
    idle_bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!fl_dq_oe_o && fl_ce_n_o && fl_we_n_o));

endmodule

// File: tb/test_flash_wr_seq.sv
`timescale 1ns/1ps
module test_flash_wr_seq;

    localparam int AW = 24;
    localparam int DW = 16;
    localparam int PERIOD_NS = 20;

    function automatic int ceil_cyc(input int t_ns);
        int c;
        c = (t_ns + PERIOD_NS - 1) / PERIOD_NS;
        return (c < 1) ? 1 : c;
    endfunction

    // expected phase lengths from the timing requirements (R9)
    int REC, CES, PW, HOLD, GAP, TOTAL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic          ack, busy, dq_oe, ce_n, we_n;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dq;

    flash_wr_seq i_flash_wr_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .addr_i     (addr),
        .data_i     (data),
        .ack_o      (ack),
        .busy_o     (busy),
        .fl_addr_o  (fl_addr),
        .fl_dq_o    (fl_dq),
        .fl_dq_oe_o (dq_oe),
        .fl_ce_n_o  (ce_n),
        .fl_we_n_o  (we_n)
    );

    always #(PERIOD_NS/2) clk = ~clk;

    int vectors = 0;
    int fails   = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req_tag, input string what,
                       input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at %0t: actual %0h expected %0h",
                     req_tag, what, $time, act, exp);
        end
    endtask

    // behavioural reference: cycles of recovery left, age of current write
    int            rec_left = 0;
    int            age = -1;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;
    int            acks_seen = 0;

    always @(negedge clk) begin
        #1;
        if (!rst_n) begin
            chk(busy == 1'b1, "R1", "busy in reset", busy, 1);
            chk(ce_n == 1'b1 && we_n == 1'b1, "R1", "ce/we in reset", {ce_n, we_n}, 2'b11);
            chk(dq_oe == 1'b0 && ack == 1'b0, "R1", "oe/ack in reset", {dq_oe, ack}, 2'b00);
            rec_left = REC;
            age = -1;
        end else begin
            bit e_busy, e_ce_n, e_we_n, e_oe, e_ack;
            e_busy = (rec_left > 0) || (age >= 0);
            e_ack  = (age == 0);
            e_ce_n = !(age >= 0 && age < CES + PW + HOLD);
            e_we_n = !(age >= CES && age < CES + PW);
            e_oe   = (age >= CES && age < CES + PW + HOLD);
            if (ack) acks_seen++;
            chk(busy == e_busy, (age >= CES + PW + HOLD) ? "R8" : "R1", "busy", busy, e_busy);
            chk(ack == e_ack, "R2", "ack", ack, e_ack);
            chk(ce_n == e_ce_n, (age >= CES + PW) ? "R7" : "R4", "ce_n", ce_n, e_ce_n);
            chk(we_n == e_we_n, "R5", "we_n", we_n, e_we_n);
            chk(dq_oe == e_oe, "R6", "dq_oe", dq_oe, e_oe);
            if (age >= 0 && age < CES + PW + HOLD) begin
                chk(fl_addr == m_addr, "R3", "address", fl_addr, m_addr);
                if (e_oe) chk(fl_dq == m_data, "R3", "data", fl_dq, m_data);
            end
            // advance model to the next cycle
            if (rec_left == 0 && age < 0 && req) begin
                age = 0;
                m_addr = addr;
                m_data = data;
            end else if (age >= 0) begin
                age++;
                if (age == TOTAL) age = -1;
            end
            if (rec_left > 0) rec_left--;
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        @(negedge clk);
        while (busy && guard < 100) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        REC   = ceil_cyc(150);
        CES   = ceil_cyc(0);
        PW    = (ceil_cyc(50) > ceil_cyc(50)) ? ceil_cyc(50) : ceil_cyc(50);
        HOLD  = ceil_cyc(0);
        GAP   = (ceil_cyc(20) > ceil_cyc(20)) ? ceil_cyc(20) : ceil_cyc(20);
        TOTAL = CES + PW + HOLD + GAP;

        // R1: request held high straight out of reset
        wait_cyc(3);
        req = 1'b1; addr = 24'h00_1234; data = 16'hA5A5;
        @(negedge clk); rst_n = 1'b1;
        wait_cyc(REC + 2);
        // R2: single write accepted after recovery; drop request
        req = 1'b0;
        wait_idle();

        // R2 and R9: distinct data patterns, one request each
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            req = 1'b1; addr = 24'h10_0000 + 24'(k * 17); data = 16'h1 << (k * 4);
            @(negedge clk);
            req = 1'b0;
            wait_idle();
        end

        // R3: request held high through back-to-back writes, inputs changing mid-write
        @(negedge clk);
        req = 1'b1; addr = 24'hFF_FFFF; data = 16'hFFFF;
        for (int k = 0; k < 3 * TOTAL; k++) begin
            @(negedge clk);
            addr = addr ^ 24'h55_AA55;
            data = ~data;
        end
        req = 1'b0;
        wait_idle();

        // R3: short request pulses while busy are ignored
        @(negedge clk);
        req = 1'b1; addr = 24'h00_0ABC; data = 16'h0F0F;
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            req = 1'b1; addr = 24'h77_7777; data = 16'h7777;
            @(negedge clk);
            req = 1'b0;
        end
        wait_idle();

        // R1: reset in the middle of a write restarts recovery
        @(negedge clk);
        req = 1'b1; addr = 24'h12_3456; data = 16'hBEEF;
        wait_cyc(3);
        rst_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(REC + TOTAL + 2);
        req = 1'b0;
        wait_idle();

        // R9: check derived phase lengths against the default timing
        chk(REC == 8 && TOTAL == 6, "R9", "cycle derivation", REC * 100 + TOTAL, 806);
        chk(acks_seen > 8, "R2", "accepted writes", acks_seen, 9);

        wait_cyc(4);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(PERIOD_NS * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule